// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Controller

This block drives one system reset line from three causes: the power-up condition, a loss of supply during operation, and expiry of a watchdog. A synchronous supply-good flag replaces the analog voltage comparator. Whenever the flag is low, or the watchdog runs out, reset is asserted. Reset is released only after the flag has been good for a fixed number of consecutive clock cycles. The same release delay follows every cause.

The chip-select line of a serial bus also serves as the watchdog service input. The line passes through a two-stage synchronizer. A high-to-low edge on it restarts the watchdog count. If no such edge arrives within the selected interval, the watchdog trips, whether the line sat high or low. A two-bit period code chooses one of three interval lengths or turns the watchdog off. All times are parameterized cycle counts. A polarity parameter selects an active-low or active-high reset pin, both built from one internal reset state.

Top module: `supervisor_reset_ctrl`

## Requirements
- R1: Out of `rst_n`, reset is asserted. With `supply_ok` high from a clock edge onward, reset is released at exactly the `HOLD_CYCLES`-th rising edge that samples it high.
- R2: A low `supply_ok` sampled at any rising edge asserts reset at that same edge.
- R3: After a brownout, release requires `HOLD_CYCLES` consecutive good samples. A single bad sample during the hold restarts the count from zero.
- R4: A high-to-low transition of `cs_n` clears the watchdog count. It takes effect at the third rising edge after the line changes, because of the two synchronizer stages and the edge detector. After that edge, a full interval must pass before the watchdog trips.
- R5: With the watchdog enabled and no falling edge on `cs_n`, reset asserts `L` rising edges after the release edge, where `L` is the selected interval. This holds whether `cs_n` sits high or sits low.
- R6: `wd_period` encoding: 2'b00 selects `WD_LONG_CYCLES`, 2'b01 selects `WD_MID_CYCLES`, 2'b10 selects `WD_SHORT_CYCLES`, and 2'b11 disables the watchdog, which then never asserts reset.
- R7: A watchdog-caused reset lasts exactly `HOLD_CYCLES` cycles. After it, the watchdog counts again from zero, so the next trip comes a full interval later.
- R8: The watchdog count is held at zero while reset is asserted or `supply_ok` is low. Time spent in reset never shortens the next interval.
- R9: With `ACTIVE_LOW`=1, `sys_rst` is low while reset is asserted. With `ACTIVE_LOW`=0 it is high. Both variants follow the same internal timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all counts are in its cycles |
| rst_n | input | 1 | Asynchronous power-up clear, active low |
| supply_ok | input | 1 | Synchronous supply-good flag |
| cs_n | input | 1 | Chip-select line, also the watchdog service input (asynchronous) |
| wd_period | input | 2 | Watchdog interval code (R6) |
| sys_rst | output | 1 | System reset output, polarity set by `ACTIVE_LOW` |

## Verification
Several rules are checked by assertions on every cycle. A bad supply sample must always put the block in reset on the next edge. Release must only follow a good sample. The watchdog count must be zero after a service edge, after any cycle in reset or with a bad supply, and while the off code is applied. The count must also never reach the longest interval. The exact cycle counts can only be shown by the bench's scenarios: the release delay, the interval for each code, a trip with `cs_n` held low, the effect of a late service edge, a glitch in the middle of the hold, and the matching output of both polarity variants.

// File: rtl/supv_pkg.sv
package supv_pkg;

   typedef enum logic [1:0] {
      WDSEL_LONG  = 2'b00,
      WDSEL_MID   = 2'b01,
      WDSEL_SHORT = 2'b10,
      WDSEL_OFF   = 2'b11
   } wd_sel_e;

   typedef struct packed {
      logic level;
      logic fall;
   } kick_t;

   function automatic int unsigned cnt_width(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/supv_cs_sync.sv
module supv_cs_sync
   import supv_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic        IDLE_LEVEL  = 1'b1
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  line_i,
   output kick_t kick_o
);

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("supv_cs_sync: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] chain_q;
   logic                   prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {SYNC_STAGES{IDLE_LEVEL}};
         prev_q  <= IDLE_LEVEL;
      end else begin
         chain_q <= {chain_q[SYNC_STAGES-2:0], line_i};
         prev_q  <= chain_q[SYNC_STAGES-1];
      end
   end

   always_comb begin
      kick_o.level = chain_q[SYNC_STAGES-1];
      kick_o.fall  = prev_q & ~chain_q[SYNC_STAGES-1];
   end

endmodule

// File: rtl/supv_hold_timer.sv
module supv_hold_timer
   import supv_pkg::*;
#(
   parameter int unsigned HOLD_CYCLES = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_ok_i,
   input  logic trip_i,
   output logic in_reset_o
);

   localparam int unsigned HW = cnt_width(HOLD_CYCLES);
   localparam logic [HW-1:0] LAST = HW'(HOLD_CYCLES - 1);

   if (HOLD_CYCLES < 2) begin : g_bad_hold
      $error("supv_hold_timer: HOLD_CYCLES must be at least 2");
   end

   logic [HW-1:0] cnt_q;
   logic          rst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_q <= 1'b1;
         cnt_q <= '0;
      end else if (!supply_ok_i || trip_i) begin
         rst_q <= 1'b1;
         cnt_q <= '0;
      end else if (rst_q) begin
         if (cnt_q == LAST) begin
            rst_q <= 1'b0;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign in_reset_o = rst_q;

endmodule

// File: rtl/supv_wdog.sv
module supv_wdog
   import supv_pkg::*;
#(
   parameter int unsigned LONG_CYCLES  = 1400,
   parameter int unsigned MID_CYCLES   = 600,
   parameter int unsigned SHORT_CYCLES = 200,
   localparam int unsigned CW          = cnt_width(LONG_CYCLES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear_i,
   input  logic          kick_i,
   input  logic [1:0]    sel_i,
   output logic          expire_o,
   output logic [CW-1:0] cnt_o
);

   if (SHORT_CYCLES < 4) begin : g_bad_short
      $error("supv_wdog: SHORT_CYCLES must be at least 4");
   end
   if (!(SHORT_CYCLES < MID_CYCLES && MID_CYCLES < LONG_CYCLES)) begin : g_bad_order
      $error("supv_wdog: intervals must satisfy SHORT < MID < LONG");
   end

   wd_sel_e       sel;
   logic          enabled;
   logic          active;
   logic [CW-1:0] last_cnt;
   logic [CW-1:0] cnt_q;

   assign sel = wd_sel_e'(sel_i);

   always_comb begin
      enabled  = 1'b1;
      last_cnt = CW'(LONG_CYCLES - 1);
      unique case (sel)
         WDSEL_LONG:  last_cnt = CW'(LONG_CYCLES - 1);
         WDSEL_MID:   last_cnt = CW'(MID_CYCLES - 1);
         WDSEL_SHORT: last_cnt = CW'(SHORT_CYCLES - 1);
         WDSEL_OFF:   enabled  = 1'b0;
         default:     enabled  = 1'b0;
      endcase
   end

   assign active   = enabled & ~clear_i;
   // >= so that switching to a shorter interval mid-count still trips
   assign expire_o = active & ~kick_i & (cnt_q >= last_cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!active || kick_i || expire_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o = cnt_q;

endmodule

// File: rtl/supervisor_reset_ctrl.sv
module supervisor_reset_ctrl
   import supv_pkg::*;
#(
   parameter int unsigned HOLD_CYCLES     = 200,
   parameter int unsigned WD_LONG_CYCLES  = 1400,
   parameter int unsigned WD_MID_CYCLES   = 600,
   parameter int unsigned WD_SHORT_CYCLES = 200,
   parameter int unsigned SYNC_STAGES     = 2,
   parameter bit          ACTIVE_LOW      = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       supply_ok,
   input  logic       cs_n,
   input  logic [1:0] wd_period,
   output logic       sys_rst
);

   localparam int unsigned CW = cnt_width(WD_LONG_CYCLES);

   kick_t         kick;
   logic          in_reset;
   logic          wd_clear;
   logic          wd_expire;
   logic [CW-1:0] wd_cnt;

   supv_cs_sync #(
      .SYNC_STAGES (SYNC_STAGES),
      .IDLE_LEVEL  (1'b1)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (cs_n),
      .kick_o (kick)
   );

   assign wd_clear = in_reset | ~supply_ok;

   supv_wdog #(
      .LONG_CYCLES  (WD_LONG_CYCLES),
      .MID_CYCLES   (WD_MID_CYCLES),
      .SHORT_CYCLES (WD_SHORT_CYCLES)
   ) u_wdog (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (wd_clear),
      .kick_i   (kick.fall),
      .sel_i    (wd_period),
      .expire_o (wd_expire),
      .cnt_o    (wd_cnt)
   );

   supv_hold_timer #(
      .HOLD_CYCLES (HOLD_CYCLES)
   ) u_hold (
      .clk         (clk),
      .rst_n       (rst_n),
      .supply_ok_i (supply_ok),
      .trip_i      (wd_expire),
      .in_reset_o  (in_reset)
   );

   if (ACTIVE_LOW) begin : g_out_low
      assign sys_rst = ~in_reset;
   end else begin : g_out_high
      assign sys_rst = in_reset;
   end

endmodule

// File: rtl/supv_checker.sv
module supv_checker #(
   parameter int unsigned CW             = 11,
   parameter int unsigned WD_LONG_CYCLES = 1400
) (
   input logic          clk,
   input logic          rst_n,
   input logic          supply_ok,
   input logic [1:0]    wd_period,
   input logic          in_reset,
   input logic          kick_fall,
   input logic [CW-1:0] wd_cnt
);

   AST_BROWNOUT_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |=> in_reset);                                          // R2

   AST_RELEASE_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_reset) |-> $past(supply_ok));                              // R3

   AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      kick_fall |=> (wd_cnt == '0));                                      // R4

   AST_WD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (in_reset || !supply_ok) |=> (wd_cnt == '0));                       // R8

   AST_WD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_period == 2'b11) |=> (wd_cnt == '0));                           // R6

   AST_WD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      wd_cnt < CW'(WD_LONG_CYCLES));                                      // R5

endmodule

bind supervisor_reset_ctrl supv_checker #(
   .CW             (CW),
   .WD_LONG_CYCLES (WD_LONG_CYCLES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .supply_ok (supply_ok),
   .wd_period (wd_period),
   .in_reset  (in_reset),
   .kick_fall (kick.fall),
   .wd_cnt    (wd_cnt)
);

// File: tb/supervisor_reset_ctrl_tb.sv
module supervisor_reset_ctrl_tb;

   localparam int CLK_PERIOD = 10;
   localparam int HOLD   = 20;
   localparam int WL     = 140;
   localparam int WM     = 60;
   localparam int WS     = 24;
   localparam int CAP    = 3000;
   localparam int LIMIT  = 100000;

   // table: period code and expected interval (0 = never trips)
   localparam logic [1:0] VEC_CODE [4] = '{2'b00, 2'b01, 2'b10, 2'b11};
   localparam int         VEC_LEN  [4] = '{WL, WM, WS, 0};

   logic       clk = 1'b0;
   logic       rst_n;
   logic       supply_ok;
   logic       cs_n;
   logic [1:0] wd_period;
   logic       rst_lo;
   logic       rst_hi;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   supervisor_reset_ctrl #(
      .HOLD_CYCLES(HOLD), .WD_LONG_CYCLES(WL), .WD_MID_CYCLES(WM),
      .WD_SHORT_CYCLES(WS), .ACTIVE_LOW(1'b1)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .cs_n(cs_n),
      .wd_period(wd_period), .sys_rst(rst_lo)
   );

   supervisor_reset_ctrl #(
      .HOLD_CYCLES(HOLD), .WD_LONG_CYCLES(WL), .WD_MID_CYCLES(WM),
      .WD_SHORT_CYCLES(WS), .ACTIVE_LOW(1'b0)
   ) u_dut_hi (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .cs_n(cs_n),
      .wd_period(wd_period), .sys_rst(rst_hi)
   );

   function automatic bit asserted();
      return (rst_lo == 1'b0);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk_pol(input string tag);
      chk(rst_hi == ~rst_lo, tag, int'(rst_hi), int'(~rst_lo));
   endtask

   task automatic wait_state(input bit want, output int n);
      n = 0;
      while (asserted() != want && n < CAP) begin
         tick();
         n++;
      end
   endtask

   task automatic fresh_start(input logic [1:0] code, input string req);
      int n;
      tick();
      supply_ok = 1'b0;
      wd_period = code;
      tick();
      tick();
      supply_ok = 1'b1;
      wait_state(1'b0, n);
      chk(n == HOLD, req, n, HOLD);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > LIMIT) begin
         errors++;
         $display("FAIL bench: watchdog expired, actual %0d expected below %0d", cycles, LIMIT);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int n;
      bit seen;
      rst_n     = 1'b0;
      supply_ok = 1'b0;
      cs_n      = 1'b1;
      wd_period = 2'b11;
      repeat (3) tick();
      chk(asserted(), "R1 reset state", int'(rst_lo), 0);
      chk_pol("R9 reset state");
      rst_n = 1'b1;
      repeat (5) tick();
      chk(asserted(), "R1 supply bad after clear", int'(rst_lo), 0);

      // R1 power-up release
      supply_ok = 1'b1;
      wait_state(1'b0, n);
      chk(n == HOLD, "R1 power-up hold", n, HOLD);
      chk_pol("R9 after release");

      // R6/R5/R7 table walk, cs_n held high
      for (int i = 0; i < 4; i++) begin
         fresh_start(VEC_CODE[i], "R8 release before table entry");
         if (VEC_LEN[i] == 0) begin
            seen = 1'b0;
            for (int k = 0; k < WL + 60; k++) begin
               tick();
               if (asserted()) seen = 1'b1;
            end
            chk(!seen, "R6 code 11 disables watchdog", int'(seen), 0);
         end else begin
            wait_state(1'b1, n);
            chk(n == VEC_LEN[i], "R6 R5 interval for code", n, VEC_LEN[i]);
            chk_pol("R9 watchdog reset");
            wait_state(1'b0, n);
            chk(n == HOLD, "R7 watchdog reset length", n, HOLD);
            wait_state(1'b1, n);
            chk(n == VEC_LEN[i], "R7 restart from zero", n, VEC_LEN[i]);
         end
      end

      // R2 immediate brownout
      fresh_start(2'b11, "R3 release");
      repeat (5) tick();
      supply_ok = 1'b0;
      tick();
      chk(asserted(), "R2 brownout asserts", int'(rst_lo), 0);
      chk_pol("R9 brownout");

      // R3 glitch during hold restarts count
      supply_ok = 1'b1;
      repeat (10) tick();
      chk(asserted(), "R3 still held mid-hold", int'(rst_lo), 0);
      supply_ok = 1'b0;
      tick();
      supply_ok = 1'b1;
      wait_state(1'b0, n);
      chk(n == HOLD, "R3 hold restarts after glitch", n, HOLD);

      // R4 periodic kicks keep reset away
      fresh_start(2'b10, "R8 release before kicks");
      seen = 1'b0;
      for (int k = 0; k < 12; k++) begin
         repeat (12) begin tick(); if (asserted()) seen = 1'b1; end
         cs_n = 1'b0;
         repeat (3) begin tick(); if (asserted()) seen = 1'b1; end
         cs_n = 1'b1;
      end
      chk(!seen, "R4 regular kicks prevent reset", int'(seen), 0);

      // R4 late kick: trip at 13 + WS ticks after release
      tick();
      supply_ok = 1'b0;
      tick();
      tick();
      supply_ok = 1'b1;
      wait_state(1'b0, n);
      chk(n == HOLD, "R3 release before late kick", n, HOLD);
      n = 0;
      while (!asserted() && n < CAP) begin
         if (n == 10) cs_n = 1'b0;
         tick();
         n++;
      end
      chk(n == 13 + WS, "R4 kick restarts interval", n, 13 + WS);

      // R5 cs_n held low from before release; R8 long reset does not count
      cs_n = 1'b0;
      tick();
      supply_ok = 1'b0;
      repeat (WS + 10) tick();
      supply_ok = 1'b1;
      wait_state(1'b0, n);
      chk(n == HOLD, "R8 release after long brownout", n, HOLD);
      wait_state(1'b1, n);
      chk(n == WS, "R5 trip with cs_n held low", n, WS);
      cs_n = 1'b1;

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule